// File: doc/BRIEF.md
# Processor interrupt level selector

This block decides which interrupt level, if any, is offered to a processor core. It merges a vector of sixteen external request lines with a software interrupt register. That register holds two timer-match flags, and both flags are routed to one fixed level. The block then picks the highest pending level that lies above the core's current interrupt level. The winner is encoded as a trap number: a trap base with the level number ORed into its low bits.

A selection is withheld in two cases. The first is when interrupts are globally disabled. The second is when the core is already inside a trap whose trap type is higher than the new trap number. When nothing at all is pending, the request is dropped and the recorded trap number returns to zero. The block also keeps a halted flag. A halt strobe sets the flag, and a new rising edge on any external line clears it.

All results are registered. Every output therefore reflects the inputs that were present at the previous clock edge.

Top module: `irq_level_sel`

## Requirements
- R1: While reset is held and right after it, `irq_pending` is 0, `trap_num` is 0 and `cpu_halted` is 0.
- R2: The pending set is `ext_lines[l]` OR `soft_reg[l]` for levels 1 to 15. External line 0 is a level that can never win. `soft_reg` bit 0 and bit 16 are never levels in their own right.
- R3: If `soft_reg` bit 0 (tick match) or bit 16 (system tick match) is set, level 14 is pending.
- R4: The winning level is the highest pending level strictly above `cur_level`. `trap_num` becomes 0x40 OR level and `irq_pending` becomes 1 one clock after the inputs are applied.
- R5: If levels are pending but none is above `cur_level`, `irq_pending` and `trap_num` keep their values.
- R6: If no level is pending, `irq_pending` becomes 0 and `trap_num` becomes 0 one clock later.
- R7: If `trap_level` is nonzero and `serviced_tt` is greater than the new trap number, the outputs keep their values. An equal `serviced_tt`, or a `trap_level` of 0, does not block the selection.
- R8: If `int_enable` is 0 and some level is pending, `irq_pending` and `trap_num` keep their values.
- R9: `halt_set` sets `cpu_halted` one clock later. A 0-to-1 change on any `ext_lines` bit clears it one clock later and takes precedence over `halt_set`. Lines that stay high do not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_lines | input | 16 | External interrupt request lines, one per level |
| soft_reg | input | 17 | Software interrupt register: bit 0 tick match, bits 15:1 levels, bit 16 system tick match |
| cur_level | input | 4 | Current processor interrupt level |
| int_enable | input | 1 | Global interrupt enable |
| trap_level | input | 3 | Current trap nesting level |
| serviced_tt | input | 9 | Trap type of the trap being serviced |
| halt_set | input | 1 | Strobe that marks the processor halted |
| irq_pending | output | 1 | Hard interrupt request to the core |
| trap_num | output | 9 | Encoded trap number of the presented level |
| cpu_halted | output | 1 | Processor halted flag |

## Verification
Every output passes through one register, so each result is due at the first rising edge after the inputs change. The driver applies a stimulus on a falling edge and records the expected result against the next cycle number. The monitor compares an entry only on the falling edge after that cycle count has been reached. Sampling half a period away from the update edge keeps the comparison clear of the edge at which the outputs change.

// File: rtl/ils_pkg.sv
package ils_pkg;
    // outcome of one evaluation of the selector
    typedef enum logic [1:0] {
        SEL_KEEP  = 2'd0,
        SEL_CLEAR = 2'd1,
        SEL_RAISE = 2'd2,
        SEL_BLOCK = 2'd3
    } sel_act_e;
endpackage

// File: rtl/ils_merge.sv
module ils_merge #(
    parameter int NUM_LEVELS  = 16,
    parameter int TIMER_LEVEL = 14
) (
    input  logic [NUM_LEVELS-1:0] ext_lines,
    input  logic [NUM_LEVELS:0]   soft_reg,
    output logic [NUM_LEVELS-1:0] pending
);
    // bit 0 and the top bit of soft_reg are timer-match flags, not levels
    logic timer_hit;
    assign timer_hit = soft_reg[0] | soft_reg[NUM_LEVELS];

    for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_lvl
        if (g == 0) begin : g_zero
            assign pending[g] = ext_lines[g];
        end else if (g == TIMER_LEVEL) begin : g_tmr
            assign pending[g] = ext_lines[g] | soft_reg[g] | timer_hit;
        end else begin : g_plain
            assign pending[g] = ext_lines[g] | soft_reg[g];
        end
    end
endmodule

// File: rtl/ils_pick.sv
module ils_pick #(
    parameter int NUM_LEVELS = 16,
    localparam int LVL_W     = $clog2(NUM_LEVELS)
) (
    input  logic [NUM_LEVELS-1:0] pending,
    input  logic [LVL_W-1:0]      cur_level,
    output logic                  found,
    output logic [LVL_W-1:0]      win_level
);
    logic [NUM_LEVELS-1:0] eligible;

    for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_elig
        assign eligible[g] = pending[g] && (LVL_W'(g) > cur_level);
    end

    // ascending scan: the last hit is the highest eligible level
    always_comb begin
        found     = 1'b0;
        win_level = '0;
        for (int l = 0; l < NUM_LEVELS; l++) begin
            if (eligible[l]) begin
                found     = 1'b1;
                win_level = LVL_W'(l);
            end
        end
    end
endmodule

// File: rtl/irq_level_sel.sv
module irq_level_sel
    import ils_pkg::*;
#(
    parameter int NUM_LEVELS  = 16,
    parameter int TT_W        = 9,
    parameter int TT_BASE     = 64,
    parameter int TL_W        = 3,
    parameter int TIMER_LEVEL = 14
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [15:0]           ext_lines,
    input  logic [16:0]           soft_reg,
    input  logic [3:0]            cur_level,
    input  logic                  int_enable,
    input  logic [2:0]            trap_level,
    input  logic [8:0]            serviced_tt,
    input  logic                  halt_set,
    output logic                  irq_pending,
    output logic [8:0]            trap_num,
    output logic                  cpu_halted
);
    localparam int LVL_W = $clog2(NUM_LEVELS);
    localparam logic [TT_W-1:0] BASE_TT = TT_W'(TT_BASE);

    typedef struct packed {
        logic                  req;
        logic [TT_W-1:0]       tt;
        logic                  halted;
        logic [NUM_LEVELS-1:0] prev;
    } sel_state_t;

    sel_state_t st_d, st_q;
    sel_act_e   act_d;

    logic [NUM_LEVELS-1:0] pending;
    logic                  found;
    logic [LVL_W-1:0]      win_level;
    logic [TT_W-1:0]       cand_tt;
    logic                  rise;

    ils_merge #(.NUM_LEVELS(NUM_LEVELS), .TIMER_LEVEL(TIMER_LEVEL)) u_merge (
        .ext_lines (ext_lines[NUM_LEVELS-1:0]),
        .soft_reg  (soft_reg[NUM_LEVELS:0]),
        .pending   (pending)
    );

    ils_pick #(.NUM_LEVELS(NUM_LEVELS)) u_pick (
        .pending   (pending),
        .cur_level (cur_level[LVL_W-1:0]),
        .found     (found),
        .win_level (win_level)
    );

    assign cand_tt = BASE_TT | TT_W'(win_level);
    assign rise    = |(ext_lines[NUM_LEVELS-1:0] & ~st_q.prev);

    always_comb begin
        st_d = st_q;
        if (pending == '0)
            act_d = SEL_CLEAR;
        else if (!int_enable || !found)
            act_d = SEL_KEEP;
        else if ((trap_level[TL_W-1:0] != '0) && (serviced_tt[TT_W-1:0] > cand_tt))
            act_d = SEL_BLOCK;
        else if (cand_tt != st_q.tt)
            act_d = SEL_RAISE;
        else
            act_d = SEL_KEEP;

        case (act_d)
            SEL_CLEAR: begin
                st_d.req = 1'b0;
                st_d.tt  = '0;
            end
            SEL_RAISE: begin
                st_d.req = 1'b1;
                st_d.tt  = cand_tt;
            end
            default: ;
        endcase

        if (rise)
            st_d.halted = 1'b0;
        else if (halt_set)
            st_d.halted = 1'b1;
        st_d.prev = ext_lines[NUM_LEVELS-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign irq_pending = st_q.req;
    assign trap_num    = 9'(st_q.tt);
    assign cpu_halted  = st_q.halted;

    // R6
    empty_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending == '0) |=> (!irq_pending && trap_num == '0));

    // R8
    masked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_enable && pending != '0) |=> ($stable(trap_num) && $stable(irq_pending)));

    // R4
    tt_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pending |-> ((trap_num >> LVL_W) == 9'(BASE_TT >> LVL_W)));

    // R5
    above_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (win_level > cur_level[LVL_W-1:0]));

    // R9
    wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !cpu_halted);
endmodule

// File: tb/irq_level_sel_bench.sv
module irq_level_sel_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] ext_lines;
    logic [16:0] soft_reg;
    logic [3:0]  cur_level;
    logic        int_enable;
    logic [2:0]  trap_level;
    logic [8:0]  serviced_tt;
    logic        halt_set;
    logic        irq_pending;
    logic [8:0]  trap_num;
    logic        cpu_halted;

    always #4 clk = ~clk;

    irq_level_sel u_irq_level_sel (
        .clk(clk), .rst_n(rst_n), .ext_lines(ext_lines), .soft_reg(soft_reg),
        .cur_level(cur_level), .int_enable(int_enable), .trap_level(trap_level),
        .serviced_tt(serviced_tt), .halt_set(halt_set), .irq_pending(irq_pending),
        .trap_num(trap_num), .cpu_halted(cpu_halted)
    );

    int cyc = 0;
    int n_checks = 0;
    int n_errors = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int         due;
        logic       req;
        logic [8:0] tt;
        logic       halted;
        string      tag;
    } exp_t;
    exp_t sbq[$];

    logic       m_req = 1'b0;
    logic [8:0] m_tt = '0;
    logic       m_halt = 1'b0;
    logic [15:0] m_prev = '0;

    task automatic step(input logic [15:0] e, input logic [16:0] s, input logic [3:0] cl,
                        input logic en, input logic [2:0] tl, input logic [8:0] stt,
                        input logic hs, input string tag);
        logic [15:0] pend;
        logic        hit;
        logic [8:0]  ntt;
        exp_t        it;
        @(negedge clk);
        ext_lines = e; soft_reg = s; cur_level = cl; int_enable = en;
        trap_level = tl; serviced_tt = stt; halt_set = hs;
        pend = e | {s[15:1], 1'b0};
        if (s[0] || s[16]) pend[14] = 1'b1;
        hit = 1'b0; ntt = '0;
        for (int l = 15; l >= 0; l--)
            if (!hit && pend[l] && l > int'(cl)) begin
                hit = 1'b1;
                ntt = 9'h040 | 9'(l);
            end
        if (pend == '0) begin
            m_req = 1'b0; m_tt = '0;
        end else if (en && hit && !(tl != 0 && stt > ntt) && ntt != m_tt) begin
            m_req = 1'b1; m_tt = ntt;
        end
        if ((e & ~m_prev) != '0) m_halt = 1'b0;
        else if (hs) m_halt = 1'b1;
        m_prev = e;
        it.due = cyc + 1; it.req = m_req; it.tt = m_tt; it.halted = m_halt; it.tag = tag;
        sbq.push_back(it);
    endtask

    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].due <= cyc) begin
            exp_t it;
            it = sbq.pop_front();
            n_checks++;
            if (irq_pending !== it.req || trap_num !== it.tt || cpu_halted !== it.halted) begin
                n_errors++;
                $display("FAIL %s: got pend=%0b tt=%h halt=%0b, exp pend=%0b tt=%h halt=%0b",
                         it.tag, irq_pending, trap_num, cpu_halted, it.req, it.tt, it.halted);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_errors++; n_checks++;
        $display("FAIL watchdog: got timeout, exp finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; ext_lines = '0; soft_reg = '0; cur_level = '0; int_enable = 1'b0;
        trap_level = '0; serviced_tt = '0; halt_set = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_checks++;
        if (irq_pending !== 1'b0 || trap_num !== 9'h0 || cpu_halted !== 1'b0) begin
            n_errors++;
            $display("FAIL R1: got pend=%0b tt=%h halt=%0b, exp 0 0 0", irq_pending, trap_num, cpu_halted);
        end
        rst_n = 1'b1;
        step(16'h0000, 17'h0, 4'd0, 1'b1, 3'd0, 9'h0, 1'b0, "R1 idle after reset");
        step(16'h0020, 17'h0, 4'd0, 1'b1, 3'd0, 9'h0, 1'b0, "R4 line 5");
        step(16'h0220, 17'h0, 4'd0, 1'b1, 3'd0, 9'h0, 1'b0, "R4 lines 5 and 9");
        step(16'h0000, 17'h0, 4'd0, 1'b1, 3'd0, 9'h0, 1'b0, "R6 empty clears");
        step(16'h0088, 17'h0, 4'd7, 1'b1, 3'd0, 9'h0, 1'b0, "R5 none above level");
        step(16'h0088, 17'h0, 4'd2, 1'b1, 3'd0, 9'h0, 1'b0, "R4 line 7 above level 2");
        step(16'h0000, 17'h0, 4'd0, 1'b1, 3'd0, 9'h0, 1'b0, "R6 empty clears again");
        step(16'h0001, 17'h0, 4'd0, 1'b1, 3'd0, 9'h0, 1'b0, "R2 line 0 never wins");
        step(16'h0000, 17'h00008, 4'd0, 1'b1, 3'd0, 9'h0, 1'b0, "R2 soft level 3");
        step(16'h0000, 17'h00001, 4'd0, 1'b1, 3'd0, 9'h0, 1'b0, "R3 tick match to 14");
        step(16'h0000, 17'h0, 4'd0, 1'b1, 3'd0, 9'h0, 1'b0, "R6 clear");
        step(16'h0000, 17'h10000, 4'd0, 1'b1, 3'd0, 9'h0, 1'b0, "R3 system tick match to 14");
        step(16'h8000, 17'h10000, 4'd0, 1'b0, 3'd0, 9'h0, 1'b0, "R8 disabled holds");
        step(16'h8000, 17'h10000, 4'd0, 1'b1, 3'd0, 9'h0, 1'b0, "R8 enabled selects 15");
        step(16'h0000, 17'h0, 4'd0, 1'b1, 3'd0, 9'h0, 1'b0, "R6 clear");
        step(16'h0040, 17'h0, 4'd0, 1'b1, 3'd1, 9'h050, 1'b0, "R7 higher serviced blocks");
        step(16'h0040, 17'h0, 4'd0, 1'b1, 3'd1, 9'h046, 1'b0, "R7 equal serviced allows");
        step(16'h0100, 17'h0, 4'd0, 1'b1, 3'd0, 9'h050, 1'b0, "R7 trap level 0 allows");
        step(16'h0100, 17'h0, 4'd0, 1'b1, 3'd0, 9'h0, 1'b1, "R9 halt set");
        step(16'h0100, 17'h0, 4'd0, 1'b1, 3'd0, 9'h0, 1'b0, "R9 steady line keeps halt");
        step(16'h0104, 17'h0, 4'd0, 1'b1, 3'd0, 9'h0, 1'b0, "R9 rising line wakes");
        step(16'h0104, 17'h0, 4'd0, 1'b1, 3'd0, 9'h0, 1'b1, "R9 halt again");
        step(16'h0106, 17'h0, 4'd0, 1'b1, 3'd0, 9'h0, 1'b1, "R9 rise beats halt strobe");
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule